// File: doc/BRIEF.md
# Condition Code Register and Branch Evaluator

This block keeps the four condition flags of a small processor (carry, zero, negative and overflow) and decides whether a conditional branch goes ahead. The ALU presents its four result flags together with a write strobe. On each clock edge where the strobe is high, the block copies the flags into its register. On every other edge the register keeps its contents. A synchronous active-low reset clears all four flags.

The sequencer places a 4-bit condition code on the selector input. The block returns a single `br_taken` bit, and the sequencer uses that bit to decide whether to load the branch target into the program counter. The decision is combinational: it depends only on the registered flags and the current selector.

The conditions cover three groups:
- single-flag tests, in both polarities;
- signed comparisons, built from N, V and Z;
- unsigned comparisons, built from C and Z.

Two further codes give an unconditional branch and a branch that is never taken.

Top module: `ccr_branch_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four flags are cleared. After reset, selector codes 0 (C clear), 3 (Z clear), 5 (N clear) and 6 (V clear) report taken, and codes 1, 2, 4 and 7 report not taken.
- R2: At a rising edge with `flag_we` high, the inputs `alu_carry`, `alu_zero`, `alu_neg` and `alu_ovf` are captured into C, Z, N and V. The captured values govern `br_taken` from just after that edge.
- R3: At a rising edge with `flag_we` low, the flags keep their values whatever the ALU flag inputs carry.
- R4: Selector 0 is taken when C=0. Selector 1 is taken when C=1.
- R5: Selector 2 is taken when Z=1. Selector 3 is taken when Z=0.
- R6: Selector 4 is taken when N=1. Selector 5 is taken when N=0.
- R7: Selector 6 is taken when V=0. Selector 7 is taken when V=1.
- R8: Selector 8 (signed greater-or-equal) is taken when N equals V. Selector 13 (signed less-than) is taken when N differs from V.
- R9: Selector 9 (signed greater-than) is taken when N equals V and Z=0. Selector 11 (signed less-or-equal) is taken when Z=1 or N differs from V.
- R10: Selector 10 (unsigned higher) is taken when C=0 and Z=0. Selector 12 (unsigned lower-or-same) is taken when C=1 or Z=1.
- R11: Selector 14 is always taken. Selector 15 is never taken.
- R12: `br_taken` follows a change of `cond_sel` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears all flags |
| flag_we | input | 1 | Flag write strobe from the ALU instruction |
| alu_carry | input | 1 | Carry out of the ALU result |
| alu_zero | input | 1 | Zero indication of the ALU result |
| alu_neg | input | 1 | Sign bit of the ALU result |
| alu_ovf | input | 1 | Two's-complement overflow of the ALU result |
| cond_sel | input | 4 | Branch condition code, 0 to 15 |
| br_taken | output | 1 | High when the selected condition holds |

## Verification
A flag write is due one edge after it is presented. The bench drives the ALU flags and the strobe half a cycle before a rising edge. It then waits until 1 ns after that edge before it reads any result.

The branch decision has no register of its own. The bench therefore changes `cond_sel` between clock edges and samples `br_taken` 1 ns later in the same cycle, which also confirms that no edge is needed.

All 16 flag combinations are loaded in turn, and each one is swept across all 16 selectors. To check that the flags hold, the bench clocks opposite ALU flags with the strobe low and then sweeps all 16 selectors again.

// File: rtl/ccr_pkg.sv
// Package ccr_pkg
// Shared types for the condition code register and the branch evaluator.
// Assumes four flags stored as one vector, indexed by the constants below.
package ccr_pkg;

    localparam int NUM_FLAGS = 4;
    localparam int SEL_W     = 4;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef enum logic [SEL_W-1:0] {
        COND_CARRY_CLR = 4'd0,
        COND_CARRY_SET = 4'd1,
        COND_EQUAL     = 4'd2,
        COND_NOT_EQUAL = 4'd3,
        COND_MINUS     = 4'd4,
        COND_PLUS      = 4'd5,
        COND_OVF_CLR   = 4'd6,
        COND_OVF_SET   = 4'd7,
        COND_SGE       = 4'd8,
        COND_SGT       = 4'd9,
        COND_UHI       = 4'd10,
        COND_SLE       = 4'd11,
        COND_ULS       = 4'd12,
        COND_SLT       = 4'd13,
        COND_ALWAYS    = 4'd14,
        COND_NEVER     = 4'd15
    } cond_e;

endpackage

// File: rtl/ccr_flag_reg.sv
// Module ccr_flag_reg
// Stores the condition flags. Each bit is a flip-flop that loads on a write
// strobe and clears under a synchronous active-low reset.
// Assumes the flag inputs settle before the rising edge.
module ccr_flag_reg
    import ccr_pkg::*;
#(
    parameter int WIDTH = NUM_FLAGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // One flag bit: clear on reset, load on strobe, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_out[i] <= 1'b0;
            end else if (wr_en) begin
                q_out[i] <= d_in[i];
            end
        end
    end

endmodule

// File: rtl/ccr_cond_eval.sv
// Module ccr_cond_eval
// Combinational branch decision over the stored flags.
// Assumes the selector uses the cond_e encoding; all 16 codes are defined.
module ccr_cond_eval
    import ccr_pkg::*;
(
    input  flag_vec_t        flags,
    input  logic [SEL_W-1:0] sel,
    output logic             taken
);

    logic c, z, n, v;
    logic sign_ok;

    // Name the individual flags and the signed agreement term.
    always_comb begin
        c       = flags[FLG_C];
        z       = flags[FLG_Z];
        n       = flags[FLG_N];
        v       = flags[FLG_V];
        sign_ok = (n == v);
    end

    // Choose the boolean test for the selected condition.
    always_comb begin
        case (cond_e'(sel))
            COND_CARRY_CLR: taken = !c;
            COND_CARRY_SET: taken = c;
            COND_EQUAL:     taken = z;
            COND_NOT_EQUAL: taken = !z;
            COND_MINUS:     taken = n;
            COND_PLUS:      taken = !n;
            COND_OVF_CLR:   taken = !v;
            COND_OVF_SET:   taken = v;
            COND_SGE:       taken = sign_ok;
            COND_SGT:       taken = sign_ok && !z;
            COND_UHI:       taken = !c && !z;
            COND_SLE:       taken = z || !sign_ok;
            COND_ULS:       taken = c || z;
            COND_SLT:       taken = !sign_ok;
            COND_ALWAYS:    taken = 1'b1;
            default:        taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/ccr_branch_unit.sv
// Module ccr_branch_unit (top)
// Captures the ALU flags under a write strobe and evaluates branch conditions.
// Assumes a synchronous active-low reset and a combinational path from the
// selector to br_taken.
module ccr_branch_unit
    import ccr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_we,
    input  logic             alu_carry,
    input  logic             alu_zero,
    input  logic             alu_neg,
    input  logic             alu_ovf,
    input  logic [SEL_W-1:0] cond_sel,
    output logic             br_taken
);

    flag_vec_t flag_d;
    flag_vec_t flags_q;

    // Pack the ALU flag inputs into the register's bit order.
    always_comb begin
        flag_d        = '0;
        flag_d[FLG_C] = alu_carry;
        flag_d[FLG_Z] = alu_zero;
        flag_d[FLG_N] = alu_neg;
        flag_d[FLG_V] = alu_ovf;
    end

    ccr_flag_reg #(.WIDTH(NUM_FLAGS)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (flag_we),
        .d_in  (flag_d),
        .q_out (flags_q)
    );

    ccr_cond_eval u_eval (
        .flags (flags_q),
        .sel   (cond_sel),
        .taken (br_taken)
    );

endmodule

// File: rtl/ccr_branch_chk.sv
// Module ccr_branch_chk
// Assertion checker bound to ccr_branch_unit. It observes the ports and the
// stored flag vector.
module ccr_branch_chk
    import ccr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             flag_we,
    input logic             alu_carry,
    input logic             alu_zero,
    input logic             alu_neg,
    input logic             alu_ovf,
    input logic [SEL_W-1:0] cond_sel,
    input logic             br_taken,
    input flag_vec_t        flags
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (flags == '0));

    // R2
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags == {$past(alu_ovf), $past(alu_neg), $past(alu_zero), $past(alu_carry)}));

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags));

    // R8
    signed_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd8) |-> (br_taken == (flags[FLG_N] == flags[FLG_V])));

    // R10
    unsigned_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd10) |-> (br_taken == (!flags[FLG_C] && !flags[FLG_Z])));

    // R11
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd14) |-> br_taken);

    // R11
    never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd15) |-> !br_taken);

endmodule

bind ccr_branch_unit ccr_branch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_we   (flag_we),
    .alu_carry (alu_carry),
    .alu_zero  (alu_zero),
    .alu_neg   (alu_neg),
    .alu_ovf   (alu_ovf),
    .cond_sel  (cond_sel),
    .br_taken  (br_taken),
    .flags     (flags_q)
);

// File: tb/tb_ccr_branch_unit.sv
`timescale 1ns/1ps
module tb_ccr_branch_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       flag_we;
    logic       alu_carry, alu_zero, alu_neg, alu_ovf;
    logic [3:0] cond_sel;
    logic       br_taken;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ccr_branch_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_we   (flag_we),
        .alu_carry (alu_carry),
        .alu_zero  (alu_zero),
        .alu_neg   (alu_neg),
        .alu_ovf   (alu_ovf),
        .cond_sel  (cond_sel),
        .br_taken  (br_taken)
    );

    // Expected decision, written from the requirement text.
    function automatic bit exp_taken(int sel, bit c, bit z, bit n, bit v);
        case (sel)
            0:  return !c;                    // R4
            1:  return c;                     // R4
            2:  return z;                     // R5
            3:  return !z;                    // R5
            4:  return n;                     // R6
            5:  return !n;                    // R6
            6:  return !v;                    // R7
            7:  return v;                     // R7
            8:  return n == v;                // R8
            9:  return (n == v) && !z;        // R9
            10: return !c && !z;              // R10
            11: return z || (n != v);         // R9
            12: return c || z;                // R10
            13: return n != v;                // R8
            14: return 1'b1;                  // R11
            default: return 1'b0;             // R11
        endcase
    endfunction

    function automatic string req_of(int sel);
        case (sel)
            0, 1:   return "R4";
            2, 3:   return "R5";
            4, 5:   return "R6";
            6, 7:   return "R7";
            8, 13:  return "R8";
            9, 11:  return "R9";
            10, 12: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Sweep all selectors between edges; each result is due 1 ns after the
    // selector change (R12), with the stored flags c,z,n,v expected.
    task automatic sweep(bit c, bit z, bit n, bit v, string ctx);
        for (int s = 0; s < 16; s++) begin
            bit e;
            cond_sel = s[3:0];
            #1;
            e = exp_taken(s, c, z, n, v);
            tests++;
            if (br_taken !== e) begin
                fails++;
                $display("FAIL %s %s/R12 sel=%0d flags CZNV=%0b%0b%0b%0b actual=%0b expected=%0b",
                         req_of(s), ctx, s, c, z, n, v, br_taken, e);
            end
        end
    endtask

    initial begin
        #150000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; flag_we = 1'b1;
        alu_carry = 1'b1; alu_zero = 1'b1; alu_neg = 1'b1; alu_ovf = 1'b1;
        cond_sel = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; flag_we = 1'b0;
        // R1: the flags are cleared even though the strobe was high during reset
        sweep(0, 0, 0, 0, "R1");

        for (int k = 0; k < 16; k++) begin
            bit c, z, n, v;
            c = k[0]; z = k[1]; n = k[2]; v = k[3];
            @(negedge clk);
            alu_carry = c; alu_zero = z; alu_neg = n; alu_ovf = v;
            flag_we = 1'b1;
            @(posedge clk);
            #1;
            flag_we = 1'b0;
            // R2: the loaded flags govern the decision after the edge
            sweep(c, z, n, v, "R2");
            // R3: with the strobe low, clock in the inverted flags
            @(negedge clk);
            alu_carry = !c; alu_zero = !z; alu_neg = !n; alu_ovf = !v;
            @(posedge clk);
            #1;
            sweep(c, z, n, v, "R3");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule